// File: doc/BRIEF.md
# NRZI Serial Frame Receiver with Digital Clock Recovery

This block takes one raw, asynchronous serial line that carries NRZI-coded frames with bit stuffing. It runs from a local clock that is a fixed multiple (OVS, four by default) of the bit rate. The line is synchronised and its transitions are detected. A small phase counter is pulled back to zero on every transition and picks one sample near the middle of each bit cell. Each sampled level is compared with the one before it to recover the plain bit.

The recovered bit stream is searched for the delimiter 0-1-1-1-1-1-1-0. A delimiter seen while hunting opens a frame, and one seen inside a frame closes it. Zeros that the sender inserted after five ones are removed. A run of seven ones inside a frame cancels it. Payload bits come out one at a time with a one-cycle valid strobe, eight recovered bits behind the line. This delay lets the delimiter's own bits be withheld. Frames are short and arrive in bursts, so the receiver locks on the first transition it sees and needs no training sequence.

Top module: `nrzi_hdlc_rx`

## Requirements
- R1: While reset is asserted, and at the first sample after it is released, `data_vld_o`, `frame_start_o`, `frame_end_o` and `abort_o` are all 0.
- R2: NRZI decoding: a change of line level between two successive bit samples is a 0, and an unchanged level is a 1. The line idles high.
- R3: While hunting, the recovered sequence 0 followed by exactly six 1s and a 0 gives exactly one `frame_start_o` pulse, and no payload is delivered for it.
- R4: Every payload bit between the opening and closing delimiters is delivered once, in line order, on `data_o` with a one-cycle `data_vld_o` pulse.
- R5: Inside a frame, a 0 that follows five consecutive 1s is dropped and gets no `data_vld_o` pulse. This also holds when the payload itself ends in five 1s.
- R6: A delimiter inside a frame gives exactly one `frame_end_o` pulse, after the last payload bit has been delivered, and returns the receiver to hunting. No delimiter bit is delivered as data.
- R7: Inside a frame, a seventh consecutive 1 gives one `abort_o` pulse and no `frame_end_o`. Bits still held in the eight-bit delay are dropped, and the receiver returns to hunting. The next frame decodes normally.
- R8: Decoding stays correct when each line transition is moved one local clock early or late relative to the nominal bit grid.
- R9: While hunting, long runs of 1s, including seven or more, give neither `abort_o` nor `data_vld_o`. `data_vld_o`, `frame_end_o` and `abort_o` only occur between a `frame_start_o` and the pulse that closes that frame.
- R10: Two `data_vld_o` pulses are always at least MID+1 (3) clock cycles apart. `frame_start_o`, `frame_end_o` and `abort_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local oversampling clock, OVS cycles per bit |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| line_i | input | 1 | Raw asynchronous NRZI line |
| data_o | output | 1 | Recovered payload bit |
| data_vld_o | output | 1 | One-cycle strobe qualifying `data_o` |
| frame_start_o | output | 1 | Pulse: opening delimiter found |
| frame_end_o | output | 1 | Pulse: closing delimiter found |
| abort_o | output | 1 | Pulse: frame cancelled by seven 1s |

## Verification
The hardest cases to reach from the pins are the ones where timing and framing interact. One is a transition that lands a cycle off the grid in the middle of a stuffed run of ones. Another is an abort arriving while the last payload bit is still inside the delay window. The stimulus uses a transmitter model that shifts every other transition by one clock. Its payload holds eight ones, so the drifted edges fall inside a stuffing sequence. The abort frame is built so that its final payload bit leaves the delay on the same bit slot as the seventh one. A reset is also asserted halfway through a frame, and the bench checks that the following frame still locks from a cold start.

// File: rtl/nrzi_rx_pkg.sv
`timescale 1ns/1ps
package nrzi_rx_pkg;
  localparam int FLAG_LEN   = 8;
  localparam int FLAG_ONES  = 6;
  localparam int STUFF_ONES = 5;
  localparam int ONES_W     = 3;

  typedef enum logic {
    ST_HUNT  = 1'b0,
    ST_FRAME = 1'b1
  } rx_state_e;
endpackage

// File: rtl/nrzi_rx_rstsync.sv
`timescale 1ns/1ps
module nrzi_rx_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] rs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rs_q <= '0;
    else         rs_q <= {rs_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = rs_q[STAGES-1];
endmodule

// File: rtl/nrzi_rx_dpll.sv
`timescale 1ns/1ps
module nrzi_rx_dpll #(
  parameter int   OVS         = 4,
  parameter int   MID         = 2,
  parameter int   SYNC_STAGES = 2,
  parameter logic IDLE_LVL    = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic stb_o,
  output logic lvl_o
);
  localparam int PW = (OVS > 1) ? $clog2(OVS) : 1;

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   last_q;
  logic [PW-1:0]          ph_q, ph_d, cur_ph;
  logic                   trans;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], line_i};
    trans  = sync_q[SYNC_STAGES-1] ^ last_q;
    // a transition marks phase zero of a new bit cell
    cur_ph = trans ? '0 : ph_q;
    ph_d   = (cur_ph == PW'(OVS-1)) ? '0 : cur_ph + PW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= {SYNC_STAGES{IDLE_LVL}};
      last_q <= IDLE_LVL;
      ph_q   <= '0;
    end else begin
      sync_q <= sync_d;
      last_q <= sync_q[SYNC_STAGES-1];
      ph_q   <= ph_d;
    end
  end

  assign stb_o = (cur_ph == PW'(MID));
  assign lvl_o = sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/nrzi_rx_decode.sv
`timescale 1ns/1ps
module nrzi_rx_decode #(
  parameter logic IDLE_LVL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stb_i,
  input  logic lvl_i,
  output logic bit_stb_o,
  output logic bit_o
);
  logic prev_q, prev_d;
  logic stb_q, bit_q, bit_d;

  always_comb begin
    prev_d = stb_i ? lvl_i : prev_q;
    bit_d  = stb_i ? (lvl_i == prev_q) : bit_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= IDLE_LVL;
      stb_q  <= 1'b0;
      bit_q  <= 1'b1;
    end else begin
      prev_q <= prev_d;
      stb_q  <= stb_i;
      bit_q  <= bit_d;
    end
  end

  assign bit_stb_o = stb_q;
  assign bit_o     = bit_q;
endmodule

// File: rtl/nrzi_rx_framer.sv
`timescale 1ns/1ps
module nrzi_rx_framer
  import nrzi_rx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_stb_i,
  input  logic bit_i,
  output logic data_o,
  output logic data_vld_o,
  output logic frame_start_o,
  output logic frame_end_o,
  output logic abort_o
);
  rx_state_e             st_q, st_d;
  logic [ONES_W-1:0]     ones_q, ones_d;
  logic [FLAG_LEN-1:0]   win_q, win_d, msk_q, msk_d;
  logic                  data_q, data_d, vld_q, vld_d;
  logic                  fs_q, fs_d, fe_q, fe_d, ab_q, ab_d;
  logic                  in_frame, flag_s, abort_s, stuff_s;

  always_comb begin
    st_d   = st_q;
    ones_d = ones_q;
    win_d  = win_q;
    msk_d  = msk_q;
    data_d = data_q;
    vld_d  = 1'b0;
    fs_d   = 1'b0;
    fe_d   = 1'b0;
    ab_d   = 1'b0;

    in_frame = (st_q == ST_FRAME);
    flag_s   = (ones_q == ONES_W'(FLAG_ONES)) && !bit_i;
    abort_s  = in_frame && (ones_q == ONES_W'(FLAG_ONES)) && bit_i;
    stuff_s  = in_frame && (ones_q == ONES_W'(STUFF_ONES)) && !bit_i;

    if (bit_stb_i) begin
      ones_d = bit_i ? ((ones_q == '1) ? ones_q : ones_q + ONES_W'(1)) : '0;
      win_d  = {win_q[FLAG_LEN-2:0], bit_i};
      msk_d  = {msk_q[FLAG_LEN-2:0], in_frame && !stuff_s && !flag_s};
      data_d = win_q[FLAG_LEN-1];
      vld_d  = msk_q[FLAG_LEN-1];
      if (flag_s) begin
        msk_d = '0;
        if (in_frame) begin
          st_d = ST_HUNT;
          fe_d = 1'b1;
        end else begin
          st_d = ST_FRAME;
          fs_d = 1'b1;
        end
      end else if (abort_s) begin
        msk_d = '0;
        st_d  = ST_HUNT;
        ab_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_HUNT;
      ones_q <= '0;
      win_q  <= '0;
      msk_q  <= '0;
      data_q <= 1'b0;
      vld_q  <= 1'b0;
      fs_q   <= 1'b0;
      fe_q   <= 1'b0;
      ab_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      ones_q <= ones_d;
      win_q  <= win_d;
      msk_q  <= msk_d;
      data_q <= data_d;
      vld_q  <= vld_d;
      fs_q   <= fs_d;
      fe_q   <= fe_d;
      ab_q   <= ab_d;
    end
  end

  assign data_o        = data_q;
  assign data_vld_o    = vld_q;
  assign frame_start_o = fs_q;
  assign frame_end_o   = fe_q;
  assign abort_o       = ab_q;
endmodule

// File: rtl/nrzi_hdlc_rx.sv
`timescale 1ns/1ps
module nrzi_hdlc_rx #(
  parameter int   OVS         = 4,
  parameter int   MID         = 2,
  parameter int   SYNC_STAGES = 2,
  parameter logic IDLE_LVL    = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic data_o,
  output logic data_vld_o,
  output logic frame_start_o,
  output logic frame_end_o,
  output logic abort_o
);
  logic rst_sync_n;
  logic smp_stb, smp_lvl;
  logic bit_stb, bit_val;

  nrzi_rx_rstsync #(.STAGES(2)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  nrzi_rx_dpll #(
    .OVS(OVS), .MID(MID), .SYNC_STAGES(SYNC_STAGES), .IDLE_LVL(IDLE_LVL)
  ) u_dpll (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .line_i (line_i),
    .stb_o  (smp_stb),
    .lvl_o  (smp_lvl)
  );

  nrzi_rx_decode #(.IDLE_LVL(IDLE_LVL)) u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .stb_i     (smp_stb),
    .lvl_i     (smp_lvl),
    .bit_stb_o (bit_stb),
    .bit_o     (bit_val)
  );

  nrzi_rx_framer u_frm (
    .clk_i         (clk_i),
    .rst_ni        (rst_sync_n),
    .bit_stb_i     (bit_stb),
    .bit_i         (bit_val),
    .data_o        (data_o),
    .data_vld_o    (data_vld_o),
    .frame_start_o (frame_start_o),
    .frame_end_o   (frame_end_o),
    .abort_o       (abort_o)
  );
endmodule

// File: rtl/nrzi_hdlc_rx_chk.sv
`timescale 1ns/1ps
module nrzi_hdlc_rx_chk #(
  parameter int MID = 2
) (
  input logic clk_i,
  input logic rst_ni,
  input logic data_vld_o,
  input logic frame_start_o,
  input logic frame_end_o,
  input logic abort_o
);
  logic       infr_q;
  logic [3:0] gap_q;

  // frame membership reconstructed purely from the output pulses
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      infr_q <= 1'b0;
      gap_q  <= '1;
    end else begin
      if (frame_start_o)                  infr_q <= 1'b1;
      else if (frame_end_o || abort_o)    infr_q <= 1'b0;
      if (data_vld_o)                     gap_q <= '0;
      else if (gap_q != '1)               gap_q <= gap_q + 4'd1;
    end
  end

  a_r10_pulses_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({frame_start_o, frame_end_o, abort_o}));

  a_r3_start_only_when_hunting: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> !infr_q);

  a_r6_end_inside_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_o |-> infr_q);

  a_r7_abort_inside_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> infr_q);

  a_r9_data_inside_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_vld_o |-> infr_q);

  a_r10_data_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_vld_o |-> (gap_q >= 4'(MID)));
endmodule

bind nrzi_hdlc_rx nrzi_hdlc_rx_chk #(.MID(MID)) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .data_vld_o    (data_vld_o),
  .frame_start_o (frame_start_o),
  .frame_end_o   (frame_end_o),
  .abort_o       (abort_o)
);

// File: tb/nrzi_hdlc_rx_tb_top.sv
`timescale 1ns/1ps
module nrzi_hdlc_rx_tb_top;
  localparam int OVS = 4;
  localparam int MID = 2;
  localparam int NV  = 8;
  // {mode[1:0], len[4:0], payload[15:0]}; mode 0 plain, 1 abort, 2 jittered edges
  localparam logic [22:0] VEC [NV] = '{
    {2'd0, 5'd8,  16'h0065},
    {2'd0, 5'd16, 16'hFFFF},
    {2'd0, 5'd12, 16'h0000},
    {2'd0, 5'd10, 16'h001F},
    {2'd1, 5'd6,  16'h002D},
    {2'd0, 5'd1,  16'h0001},
    {2'd0, 5'd0,  16'h0000},
    {2'd2, 5'd16, 16'h3FC3}
  };

  logic clk;
  logic rst_ni;
  logic line;
  logic data, data_vld, fs, fe, ab;

  int n_chk, n_fail;
  int rx_n, fs_n, fe_n, ab_n;
  logic rx_bits [64];
  int gap, min_gap;
  bit jit;
  int tcnt;
  int ones_tx;

  nrzi_hdlc_rx #(.OVS(OVS), .MID(MID)) dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .line_i        (line),
    .data_o        (data),
    .data_vld_o    (data_vld),
    .frame_start_o (fs),
    .frame_end_o   (fe),
    .abort_o       (ab)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    if (gap < 1000) gap++;
    if (rst_ni) begin
      if (data_vld) begin
        if (rx_n < 64) rx_bits[rx_n] = data;
        rx_n++;
        if (gap < min_gap) min_gap = gap;
        gap = 0;
      end
      if (fs) fs_n++;
      if (fe) fe_n++;
      if (ab) ab_n++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  task automatic clr();
    rx_n = 0; fs_n = 0; fe_n = 0; ab_n = 0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // transmitter model: NRZI, a 0 toggles the line
  task automatic send_bit(input logic b);
    if (!b) begin
      if (jit && tcnt[0]) begin
        wait_cyc(1); line = ~line; wait_cyc(OVS - 1);
      end else begin
        line = ~line; wait_cyc(OVS);
      end
      tcnt++;
    end else begin
      wait_cyc(OVS);
    end
  endtask

  task automatic send_flag();
    send_bit(1'b0);
    for (int i = 0; i < 6; i++) send_bit(1'b1);
    send_bit(1'b0);
    ones_tx = 0;
  endtask

  task automatic send_stuffed(input logic b);
    send_bit(b);
    if (b) begin
      ones_tx++;
      if (ones_tx == 5) begin
        send_bit(1'b0);
        ones_tx = 0;
      end
    end else ones_tx = 0;
  endtask

  task automatic idle_bits(input int n);
    wait_cyc(n * OVS);
  endtask

  task automatic run_frame(input logic [22:0] vec, input string tag);
    logic [1:0]  mode;
    logic [4:0]  len;
    logic [15:0] pl;
    int          bad;
    {mode, len, pl} = vec;
    clr();
    jit  = (mode == 2'd2);
    tcnt = 0;
    send_flag();
    for (int i = 0; i < int'(len); i++) send_stuffed(pl[i]);
    if (mode == 2'd1) begin
      send_bit(1'b0);
      for (int i = 0; i < 7; i++) send_bit(1'b1);
    end else begin
      send_flag();
    end
    jit = 1'b0;
    idle_bits(24);
    bad = 0;
    for (int i = 0; i < int'(len) && i < rx_n && i < 64; i++)
      if (rx_bits[i] !== pl[i]) bad++;
    chk(fs_n == 1, "R3 frame_start count", fs_n, 1);
    chk(rx_n == int'(len), "R4 delivered bit count", rx_n, int'(len));
    chk(bad == 0, {tag, " payload bits wrong"}, bad, 0);
    if (mode == 2'd1) begin
      chk(ab_n == 1, "R7 abort count", ab_n, 1);
      chk(fe_n == 0, "R7 frame_end after abort", fe_n, 0);
    end else begin
      chk(fe_n == 1, "R6 frame_end count", fe_n, 1);
      chk(ab_n == 0, "R6 no abort", ab_n, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    gap = 1000; min_gap = 1000;
    jit = 1'b0; tcnt = 0; ones_tx = 0;
    clr();
    line   = 1'b1;
    rst_ni = 1'b0;
    wait_cyc(5);
    chk({data_vld, fs, fe, ab} == 4'b0, "R1 outputs in reset", int'({data_vld, fs, fe, ab}), 0);
    rst_ni = 1'b1;
    wait_cyc(1);
    chk({data_vld, fs, fe, ab} == 4'b0, "R1 outputs after release", int'({data_vld, fs, fe, ab}), 0);

    // R9: long idle ones plus a non-flag burst of eight ones while hunting
    idle_bits(20);
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(1'b1);
    send_bit(1'b0);
    idle_bits(20);
    chk(ab_n == 0, "R9 no abort while hunting", ab_n, 0);
    chk(rx_n == 0, "R9 no data while hunting", rx_n, 0);
    chk(fs_n == 0, "R9 no frame_start on non-flag", fs_n, 0);

    // table-driven frames
    for (int v = 0; v < NV; v++) begin
      string tag;
      if (v == 1 || v == 3) tag = "R5";
      else if (v == 7)      tag = "R8";
      else                  tag = "R2";
      run_frame(VEC[v], tag);
    end

    // reset in the middle of a frame
    clr();
    send_flag();
    for (int i = 0; i < 5; i++) send_stuffed(i[0]);
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk({data_vld, fs, fe, ab} == 4'b0, "R1 outputs on mid-frame reset", int'({data_vld, fs, fe, ab}), 0);
    wait_cyc(3);
    line = 1'b1;
    rst_ni = 1'b1;
    idle_bits(16);
    run_frame({2'd0, 5'd9, 16'h0156}, "R4");

    chk(min_gap >= MID + 1, "R10 data strobe spacing", min_gap, MID + 1);

    summary();
    $finish;
  end
endmodule